// File: doc/BRIEF.md
# Streaming-Load Line Fill Buffers

This block sits between a core load port and a memory port for uncached, write-combining address ranges. A load that carries the streaming hint and targets a write-combining range reads a whole 64-byte line from memory and parks it in one of a small pool of line buffers. A later streaming load that falls inside a parked line is answered from the buffer one cycle after it is accepted, with no memory traffic. An ordinary load to a write-combining range reads only the bytes it asks for. Any load to a write-back range ignores the streaming hint and is sent to memory at its own size, as an ordinary load.

The block handles one load at a time. A load that needs memory holds the request channel not ready until its data comes back, so a second streaming load to a line still being filled waits and is then served from that line's buffer, without a second line read. Buffers are handed out in a fixed rotation, so a miss with every buffer in use replaces the line that was brought in longest ago. A flush input drops every parked line in one cycle.

Top module: `wc_stream_fill`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: A streaming load (`req_stream_i`=1) to a write-combining range (`req_wc_i`=1) that matches no valid buffer issues one memory read with `mem_req_size_o`=6 (64 bytes) at the line-aligned address (low 6 bits zero). Its response carries the requested bytes, taken from the line at the load's offset.
- R3: A streaming write-combining load that falls within a valid buffer issues no memory read, and `rsp_valid_o` is 1 in the cycle after the load is accepted.
- R4: An ordinary load (`req_stream_i`=0) to a write-combining range issues one memory read at its exact address with `mem_req_size_o` equal to `req_size_i` (log2 of bytes, 0 to 4). It allocates no buffer, so a following streaming load to that line still reads memory.
- R5: Any load to a write-back range (`req_wc_i`=0) behaves as in R4 whatever `req_stream_i` is: it reads its own size and allocates no buffer.
- R6: Buffers are allocated in index order starting at 0 after reset or flush and wrapping after `N_BUF`-1. With all buffers in use, a new line replaces the one loaded longest ago, and the other lines stay resident.
- R7: While a memory read is outstanding, `req_ready_o` is 0. A streaming load to the line being filled that follows it is served from the buffer and issues no second read.
- R8: `flush_i` drops every buffer in the cycle it is high and holds `req_ready_o` at 0 during that cycle. A line parked before the flush needs a new memory read.
- R9: A flush that falls in the cycle a line fill returns still delivers the correct response for that load, but the line is not kept.
- R10: Once raised, `mem_req_valid_o`, `mem_req_addr_o` and `mem_req_size_o` hold steady until `mem_req_ready_i` accepts the read.
- R11: `rsp_data_o` holds the 2^size requested bytes right-aligned, lowest address in bits 7:0, and all higher bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all parked lines |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Load request accepted when high with valid |
| req_addr_i | input | ADDR_W | Load byte address, aligned to its size |
| req_size_i | input | 3 | log2 of load bytes, 0 to 4 |
| req_stream_i | input | 1 | Streaming hint |
| req_wc_i | input | 1 | 1: write-combining range, 0: write-back range |
| rsp_valid_o | output | 1 | Load data valid for one cycle |
| rsp_data_o | output | 128 | Load data, right-aligned |
| mem_req_valid_o | output | 1 | Memory read valid |
| mem_req_ready_i | input | 1 | Memory read accepted |
| mem_req_addr_o | output | ADDR_W | Memory read address |
| mem_req_size_o | output | 3 | log2 of read bytes (6 = full line) |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | 512 | Read data, right-aligned |

## Verification
The collision that matters is a flush landing in the same cycle as a line fill's data return, where invalidation and installation meet on the same buffer. The bench arranges it by having its memory model raise `flush_i` on exactly the cycle it drives the fill data back. It then judges that the load still receives the correct bytes and that a repeat streaming load to the same line issues a fresh line read.

// File: rtl/slfb_pkg.sv
package slfb_pkg;
  localparam int LINE_BYTES = 64;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int RSP_BYTES  = 16;
  localparam int RSP_W      = RSP_BYTES * 8;
  localparam logic [2:0] SZ_LINE = 3'(OFF_W);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;

  // select 2^sz bytes starting at byte off, zero the rest
  function automatic logic [RSP_W-1:0] pick(input logic [LINE_W-1:0] src,
                                             input logic [OFF_W-1:0]  off,
                                             input logic [2:0]        sz);
    logic [LINE_W-1:0] sh;
    logic [RSP_W-1:0]  m;
    sh = src >> {off, 3'b000};
    m  = '0;
    for (int b = 0; b < RSP_BYTES; b++)
      if (b < (1 << sz)) m[b*8 +: 8] = 8'hff;
    return sh[RSP_W-1:0] & m;
  endfunction
endpackage

// File: rtl/slfb_tags.sv
module slfb_tags #(
  parameter int N_BUF = 10,
  parameter int TAG_W = 26,
  localparam int IDX_W = $clog2(N_BUF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] victim_o,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i
);
  logic [N_BUF-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [N_BUF];
  logic [IDX_W-1:0] rr_q;
  logic [N_BUF-1:0] match;

  for (genvar g = 0; g < N_BUF; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == look_tag_i);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = 0; i < N_BUF; i++)
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
  end

  assign victim_o = rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
      for (int i = 0; i < N_BUF; i++) tag_q[i] <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      if (alloc_i) begin
        valid_q[rr_q] <= 1'b0;
        tag_q[rr_q]   <= look_tag_i;
        rr_q          <= (rr_q == IDX_W'(N_BUF - 1)) ? '0 : rr_q + 1'b1;
      end
      if (fill_i) valid_q[fill_idx_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/slfb_lines.sv
module slfb_lines #(
  parameter int N_BUF  = 10,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(N_BUF)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [LINE_W-1:0] rdata_o
);
  logic [LINE_W-1:0] line_q [N_BUF];

  always_ff @(posedge clk_i) begin
    if (we_i) line_q[widx_i] <= wdata_i;
  end

  assign rdata_o = line_q[ridx_i];
endmodule

// File: rtl/wc_stream_fill.sv
module wc_stream_fill
  import slfb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_BUF  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  input  logic              req_stream_i,
  input  logic              req_wc_i,
  output logic              rsp_valid_o,
  output logic [RSP_W-1:0]  rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [2:0]        mem_req_size_o,
  input  logic              mem_rsp_valid_i,
  input  logic [LINE_W-1:0] mem_rsp_data_i
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(N_BUF);

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic              line_q, kill_q;
  logic [IDX_W-1:0]  idx_q;
  logic              rsp_valid_q;
  logic [RSP_W-1:0]  rsp_data_q;

  logic              use_buf, accept, hit, hit_fire, miss_fire, alloc;
  logic              fill_done, fill_install;
  logic [IDX_W-1:0]  hit_idx, victim;
  logic [LINE_W-1:0] buf_line;

  assign use_buf     = req_stream_i & req_wc_i;
  assign req_ready_o = (state_q == ST_IDLE) & ~flush_i;
  assign accept      = req_valid_i & req_ready_o;
  assign hit_fire    = accept & use_buf & hit;
  assign miss_fire   = accept & ~(use_buf & hit);
  assign alloc       = accept & use_buf & ~hit;

  assign fill_done    = (state_q == ST_WAIT) & mem_rsp_valid_i;
  assign fill_install = fill_done & line_q & ~kill_q & ~flush_i;

  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = line_q ? {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : addr_q;
  assign mem_req_size_o  = line_q ? SZ_LINE : size_q;

  slfb_tags #(.N_BUF(N_BUF), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .look_tag_i (req_addr_i[ADDR_W-1:OFF_W]),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .alloc_i    (alloc),
    .victim_o   (victim),
    .fill_i     (fill_install),
    .fill_idx_i (idx_q)
  );

  slfb_lines #(.N_BUF(N_BUF), .LINE_W(LINE_W)) u_lines (
    .clk_i   (clk_i),
    .we_i    (fill_done & line_q),
    .widx_i  (idx_q),
    .wdata_i (mem_rsp_data_i),
    .ridx_i  (hit_idx),
    .rdata_o (buf_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      size_q      <= '0;
      line_q      <= 1'b0;
      kill_q      <= 1'b0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= hit_fire | fill_done;
      if (hit_fire)
        rsp_data_q <= pick(buf_line, req_addr_i[OFF_W-1:0], req_size_i);
      else if (fill_done)
        rsp_data_q <= pick(mem_rsp_data_i, line_q ? addr_q[OFF_W-1:0] : '0, size_q);
      unique case (state_q)
        ST_IDLE: if (miss_fire) begin
          state_q <= ST_REQ;
          addr_q  <= req_addr_i;
          size_q  <= req_size_i;
          line_q  <= use_buf;
          idx_q   <= victim;
          kill_q  <= 1'b0;
        end
        ST_REQ:  if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      // a flush while a fill is outstanding cancels its install
      if (flush_i) kill_q <= 1'b1;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/slfb_checker.sv
module slfb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [2:0]        mem_req_size_o,
  input logic              mem_rsp_valid_i
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_size_o));

  p_busy_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  p_flush_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);

  p_line_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_size_o == 3'd6 |-> mem_req_addr_o[5:0] == 6'd0);

  p_size_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_size_o <= 3'd4) || (mem_req_size_o == 3'd6));

  p_rsp_no_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_valid_o);

  p_fill_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i && !req_ready_o && !mem_req_valid_o |=> rsp_valid_o);
endmodule

bind wc_stream_fill slfb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_size_o  (mem_req_size_o),
  .mem_rsp_valid_i (mem_rsp_valid_i)
);

// File: tb/wc_stream_fill_test.sv
`timescale 1ns/1ps
module wc_stream_fill_test;
  localparam int AW = 32;
  localparam int NB = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_a = 1'b0, flush_b = 1'b0;
  logic flush_i;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [2:0] req_size_i = '0;
  logic req_stream_i = 1'b0, req_wc_i = 1'b0;
  logic rsp_valid_o;
  logic [127:0] rsp_data_o;
  logic mem_req_valid_o, mem_req_ready_i;
  logic [AW-1:0] mem_req_addr_o;
  logic [2:0] mem_req_size_o;
  logic mem_rsp_valid_i;
  logic [511:0] mem_rsp_data_i;

  assign flush_i = flush_a | flush_b;
  always #2.5 clk = ~clk;

  wc_stream_fill #(.ADDR_W(AW), .N_BUF(NB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .req_size_i(req_size_i), .req_stream_i(req_stream_i), .req_wc_i(req_wc_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_req_size_o(mem_req_size_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i)
  );

  int checks = 0, fails = 0, mem_reads = 0;
  int force_lat = 0;
  bit flush_on_rsp = 0;
  logic [AW-1:0] last_addr;
  logic [2:0] last_size;
  logic [25:0] m_tag [NB];
  bit m_val [NB];
  int m_rr = 0;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return 8'((a * 32'd29) ^ (a >> 6));
  endfunction

  function automatic logic [127:0] exp_data(input logic [31:0] a, input logic [2:0] sz);
    logic [127:0] d = '0;
    for (int j = 0; j < 16; j++) if (j < (1 << sz)) d[j*8 +: 8] = mb(a + 32'(j));
    return d;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NB; i++) m_val[i] = 0;
    m_rr = 0;
  endtask

  // memory model: random accept, random latency, data from mb()
  initial begin
    bit busy = 0;
    int cnt = 0;
    logic [AW-1:0] a_r = '0;
    logic [2:0] s_r = '0;
    mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      flush_b = 1'b0;
      if (busy) begin
        mem_req_ready_i = 1'b0;
        if (cnt == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i = '0;
          for (int j = 0; j < 64; j++)
            if (j < (1 << s_r)) mem_rsp_data_i[j*8 +: 8] = mb(a_r + 32'(j));
          flush_b = flush_on_rsp;
          flush_on_rsp = 0;
          busy = 0;
        end else cnt--;
      end else begin
        mem_req_ready_i = ($urandom % 3) != 0;
        if (mem_req_valid_o && mem_req_ready_i) begin
          busy = 1;
          cnt = (force_lat > 0) ? force_lat - 1 : int'($urandom % 5);
          a_r = mem_req_addr_o; s_r = mem_req_size_o;
          last_addr = mem_req_addr_o; last_size = mem_req_size_o;
          mem_reads++;
        end
      end
    end
  end

  // called and returns at a negedge
  task automatic do_load(input logic [31:0] a, input logic [2:0] sz, input bit st, input bit wc, input string ctx);
    bit use_buf = st && wc;
    bit hit = 0;
    bit rdy_bad = 0;
    int r0, n;
    string tg;
    logic [127:0] exp;
    for (int i = 0; i < NB; i++) if (m_val[i] && m_tag[i] == a[31:6]) hit = 1;
    hit = hit && use_buf;
    tg = !wc ? "R5" : !st ? "R4" : hit ? "R3" : "R2";
    exp = exp_data(a, sz);
    r0 = mem_reads;
    req_valid_i = 1'b1; req_addr_i = a; req_size_i = sz; req_stream_i = st; req_wc_i = wc;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (hit) check(rsp_valid_o, {tg, " hit latency ", ctx}, 128'(rsp_valid_o), 128'd1);
    else begin
      n = 0;
      while (!rsp_valid_o && n < 200) begin
        if (req_ready_o) rdy_bad = 1;
        @(negedge clk); n++;
      end
      check(!rdy_bad, {"R7 ready low while busy ", ctx}, 128'(rdy_bad), 128'd0);
      check(last_size == (use_buf ? 3'd6 : sz), {tg, " read size ", ctx}, 128'(last_size),
            128'(use_buf ? 3'd6 : sz));
      check(last_addr == (use_buf ? {a[31:6], 6'd0} : a), {tg, " R10 read addr ", ctx},
            128'(last_addr), 128'(use_buf ? {a[31:6], 6'd0} : a));
    end
    check(rsp_valid_o && rsp_data_o == exp, {tg, " R11 data ", ctx}, rsp_data_o, exp);
    check(mem_reads - r0 == (hit ? 0 : 1), {tg, " read count ", ctx}, 128'(mem_reads - r0),
          128'(hit ? 0 : 1));
    if (use_buf && !hit) begin
      m_tag[m_rr] = a[31:6]; m_val[m_rr] = 1; m_rr = (m_rr + 1) % NB;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7301));
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R1 reset state",
          128'({req_ready_o, rsp_valid_o, mem_req_valid_o}), 128'(3'b100));

    do_load(32'h1010, 3'd4, 1, 1, "R2 first line fill");
    do_load(32'h1003, 3'd0, 1, 1, "R3 byte hit");
    do_load(32'h1038, 3'd3, 1, 1, "R3 R11 top of line");
    do_load(32'h2004, 3'd2, 0, 1, "R4 plain wc");
    do_load(32'h2008, 3'd2, 1, 1, "R4 no alloc after plain");
    do_load(32'h3000, 3'd3, 1, 0, "R5 wb streaming");
    do_load(32'h3008, 3'd1, 1, 0, "R5 wb again");
    do_load(32'h3010, 3'd4, 1, 1, "R5 no alloc after wb");
    do_load(32'h5000, 3'd2, 1, 1, "R7 fill");
    do_load(32'h5020, 3'd2, 1, 1, "R7 follow-up hit");

    // R8 flush drops all lines
    flush_a = 1'b1; #1;
    check(!req_ready_o, "R8 ready low in flush", 128'(req_ready_o), 128'd0);
    @(negedge clk); flush_a = 1'b0;
    model_clear();
    do_load(32'h1000, 3'd2, 1, 1, "R8 refetch after flush");

    // R6 rotation: fill 11 lines after a flush
    flush_a = 1'b1; @(negedge clk); flush_a = 1'b0;
    model_clear();
    for (int i = 0; i < 11; i++) do_load(32'h10000 + 32'(i * 64), 3'd3, 1, 1, "R6 fill");
    do_load(32'h10040, 3'd3, 1, 1, "R6 second line resident");
    do_load(32'h10000, 3'd3, 1, 1, "R6 oldest evicted");

    // R9 flush in the fill-return cycle
    force_lat = 2; flush_on_rsp = 1;
    do_load(32'h7010, 3'd4, 1, 1, "R9 data despite flush");
    model_clear();
    force_lat = 0;
    do_load(32'h7000, 3'd2, 1, 1, "R9 line not kept");

    for (int k = 0; k < 400; k++) begin
      logic [2:0] sz = 3'($urandom % 5);
      logic [31:0] a = 32'h4000 + 32'(($urandom % 14) * 64) + (32'($urandom % 64) & ~((32'd1 << sz) - 1));
      do_load(a, sz, 1'($urandom % 4 != 0), 1'($urandom % 5 != 0), "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule